// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is the operand store of a processor datapath: a parameterised bank of equal-width registers, addressed by register number, with two read ports and one write port that all work in the same clock cycle. An execution stage presents two source register numbers and gets both operands back at once. It then returns one result, together with its destination number and a write strobe, and the result is stored on the next rising clock edge.

The read ports are purely combinational: a read port's data follows its address and the stored contents with no register in between. The write port is synchronous. When a read port names the register that is being written in the same cycle, it returns the old contents. The new value appears only after the clock edge. A build-time option turns register 0 into a constant zero source. In that mode register 0 has no storage, writes aimed at it are dropped, and reads of it always give zero. A synchronous, active-high reset clears every stored register.

Top module: `regfile_2r1w`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every register is cleared to zero. After that edge, both read ports return zero for every address until a write occurs.
- R2: When `wr_en` is high at a rising edge and `rst` is low, the register numbered `wr_addr` takes `wr_data`, and every other register keeps its value.
- R3: When `wr_en` is low at a rising edge, no register changes, whatever `wr_addr` and `wr_data` hold.
- R4: Each read port returns the register selected by its own address, combinationally in the same cycle. The two ports can select different registers independently.
- R5: If a read port addresses the register that is being written in that cycle, it returns the value held before the edge. The new value is visible from the edge onward.
- R6: When both read addresses are equal, both ports return the same register value.
- R7: With `R0_MODE = R0_ZERO`, address 0 reads as zero on both ports at all times, and writes to address 0 have no effect.
- R8: With `R0_MODE = R0_STORED`, register 0 is ordinary storage that can be written and read back like any other register.
- R9: Starting with register 1 = 25 and register 2 = 17, reading port A at address 1 and port B at address 2 while writing 42 to address 3 returns 25 and 17 in that cycle. Afterwards registers 0 to 2 are unchanged and register 3 reads 42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| wr_en | input | 1 | Write strobe for the write port |
| wr_addr | input | ADDR_W | Destination register number |
| wr_data | input | DATA_W | Value to store |
| rd_addr_a | input | ADDR_W | Register number for read port A |
| rd_addr_b | input | ADDR_W | Register number for read port B |
| rd_data_a | output | DATA_W | Contents of the register selected on port A |
| rd_data_b | output | DATA_W | Contents of the register selected on port B |

## Verification
The assertions assume that every input is a known value at each rising edge, that inputs change only away from that edge, and that reset is held high for the first edges so that storage is defined before any property can fire. The stimulus meets these conditions. It drives all inputs on the falling edge, starts with reset high for several cycles, and takes addresses from the full power-of-two range, so every address names a real register. Random writes, random read addresses and forced same-address collisions are applied to a stored-register-0 instance and a hardwired-zero instance that share the same inputs.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // How register 0 is built.
    typedef enum logic {
        R0_STORED = 1'b0,   // ordinary storage
        R0_ZERO   = 1'b1    // constant zero, writes dropped
    } r0_mode_e;

    // Address width for a register count (at least one bit).
    function automatic int addr_bits(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/regfile_wdec.sv
module regfile_wdec #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 2
) (
    input  logic                en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] load
);

    // One-hot select, gated by the global write strobe.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            load[i] = en && (addr == ADDR_W'(i));
        end
    end

endmodule

// File: rtl/regfile_rdmux.sv
module regfile_rdmux #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] bank,
    input  logic [ADDR_W-1:0]               sel,
    output logic [DATA_W-1:0]               dout
);

    always_comb begin
        dout = bank[sel];
    end

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import regfile_pkg::*;
#(
    parameter int       DATA_W   = 8,
    parameter int       NUM_REGS = 4,
    parameter r0_mode_e R0_MODE  = R0_STORED,
    localparam int      ADDR_W   = addr_bits(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);

    logic [NUM_REGS-1:0]             load;
    logic [NUM_REGS-1:0][DATA_W-1:0] bank;

    regfile_wdec #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_wdec (
        .en   (wr_en),
        .addr (wr_addr),
        .load (load)
    );

    // Storage: one register per entry, or a constant for entry 0 in zero mode.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (R0_MODE == R0_ZERO && i == 0) begin : g_const
            logic unused_load;
            assign unused_load = load[i];
            assign bank[i]     = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (load[i]) begin
                    q <= wr_data;
                end
            end
            assign bank[i] = q;
        end
    end

    // Read ports: one independent multiplexer each, old value on collision.
    regfile_rdmux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rd_a (
        .bank (bank),
        .sel  (rd_addr_a),
        .dout (rd_data_a)
    );

    regfile_rdmux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rd_b (
        .bank (bank),
        .sel  (rd_addr_b),
        .dout (rd_data_b)
    );

endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk
    import regfile_pkg::*;
#(
    parameter int       DATA_W   = 8,
    parameter int       NUM_REGS = 4,
    parameter r0_mode_e R0_MODE  = R0_STORED,
    localparam int      ADDR_W   = addr_bits(NUM_REGS)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);

    localparam bit ZERO0 = (R0_MODE == R0_ZERO);

    // The cycle after a reset edge, all reads are zero.
    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0));

    // A written register reads back the written value on the next cycle.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && rd_addr_a == $past(wr_addr)
         && !(ZERO0 && rd_addr_a == '0))
        |-> rd_data_a == $past(wr_data));

    // A register not written keeps its value (port A, fixed address).
    assert_hold_unwritten_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(rd_addr_a)
         && (!$past(wr_en) || $past(wr_addr) != rd_addr_a))
        |-> $stable(rd_data_a));

    // Same address on both ports gives the same data.
    assert_same_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

    // Hardwired register 0 always reads zero.
    assert_zero_reg_a_R7: assert property (@(posedge clk) disable iff (rst)
        (ZERO0 && rd_addr_a == '0) |-> rd_data_a == '0);
    assert_zero_reg_b_R7: assert property (@(posedge clk) disable iff (rst)
        (ZERO0 && rd_addr_b == '0) |-> rd_data_b == '0);

endmodule

bind regfile_2r1w regfile_2r1w_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .R0_MODE  (R0_MODE)
) u_chk (.*);

// File: tb/regfile_2r1w_test.sv
module regfile_2r1w_test;
    import regfile_pkg::*;

    localparam int DW = 8;
    localparam int NR = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr_a = '0;
    logic [AW-1:0] rd_addr_b = '0;
    logic [DW-1:0] rd_data_a, rd_data_b, z_data_a, z_data_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] mdl   [NR];
    logic [DW-1:0] mdl_z [NR];

    always #5 clk = ~clk;

    regfile_2r1w #(.DATA_W(DW), .NUM_REGS(NR), .R0_MODE(R0_STORED)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b));

    regfile_2r1w #(.DATA_W(DW), .NUM_REGS(NR), .R0_MODE(R0_ZERO)) uut_z (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(z_data_a), .rd_data_b(z_data_b));

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        return mdl[a];
    endfunction

    function automatic logic [DW-1:0] exp_rd_z(input logic [AW-1:0] a);
        return (a == '0) ? '0 : mdl_z[a];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive on falling edge, compare before the rising edge, then update model.
    task automatic step(input string req, input logic r, input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic [AW-1:0] ra, input logic [AW-1:0] rb);
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
        #1;
        if (!r) begin
            // R4/R5: same-cycle read returns pre-edge contents
            check({req, " port A"},   rd_data_a, exp_rd(ra));
            check({req, " port B"},   rd_data_b, exp_rd(rb));
            check({req, " R7 zero A"}, z_data_a, exp_rd_z(ra));
            check({req, " R7 zero B"}, z_data_b, exp_rd_z(rb));
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < NR; i++) begin mdl[i] = '0; mdl_z[i] = '0; end
        end else if (we) begin
            mdl[wa] = wd;
            if (wa != '0) mdl_z[wa] = wd;
        end
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < NR; i++) step(req, 1'b0, 1'b0, '0, '0, AW'(i), AW'(NR - 1 - i));
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin mdl[i] = '0; mdl_z[i] = '0; end
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) step("R1 reset", 1'b1, 1'b0, '0, '0, '0, '0);
        read_all("R1 after reset");

        // R8: register 0 stores normally; R7: zero instance drops it
        step("R8 write r0", 1'b0, 1'b1, 2'd0, 8'hA5, 2'd0, 2'd0);
        step("R8 read r0", 1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 2'd1);
        step("R7 write r0 again", 1'b0, 1'b1, 2'd0, 8'h3C, 2'd0, 2'd0);
        read_all("R7/R8 readback");

        // R9: worked example
        step("R9 set r1", 1'b0, 1'b1, 2'd1, 8'd25, 2'd0, 2'd0);
        step("R9 set r2", 1'b0, 1'b1, 2'd2, 8'd17, 2'd1, 2'd1);
        step("R9 add cycle", 1'b0, 1'b1, 2'd3, 8'd42, 2'd1, 2'd2);
        check("R9 r1 on A", rd_data_a, 8'd25);
        check("R9 r2 on B", rd_data_b, 8'd17);
        read_all("R9 after");
        step("R9 r3", 1'b0, 1'b0, 2'd0, 8'd0, 2'd3, 2'd0);
        check("R9 r3 value", rd_data_a, 8'd42);

        // R3: strobe low with live address and data
        step("R3 no strobe", 1'b0, 1'b0, 2'd2, 8'hFF, 2'd2, 2'd2);
        step("R3 no strobe", 1'b0, 1'b0, 2'd1, 8'hEE, 2'd2, 2'd1);
        read_all("R3 after");

        // R5: read the register under write on both ports
        step("R5 collision", 1'b0, 1'b1, 2'd2, 8'h77, 2'd2, 2'd2);
        step("R5 new value", 1'b0, 1'b0, 2'd0, 8'h00, 2'd2, 2'd0);
        check("R5 new on A", rd_data_a, 8'h77);

        // R2/R4/R6: random traffic with forced same-address cases
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] ra, rb, wa;
            ra = AW'($urandom);
            rb = ($urandom % 4 == 0) ? ra : AW'($urandom);
            wa = ($urandom % 3 == 0) ? ra : AW'($urandom);
            step("R2 R4 R6 random", 1'b0, 1'($urandom), wa, DW'($urandom), ra, rb);
        end

        // R1: reset in mid-run
        step("R1 reset mid", 1'b1, 1'b1, 2'd1, 8'h11, 2'd1, 2'd1);
        read_all("R1 mid reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule